// File: doc/BRIEF.md
# Descriptor Ring Retirement Tracker

This block follows a DMA engine as it consumes a circular ring of transmit descriptors and retires the requests that occupy the ring, strictly in submission order. Each request is held in a small queue. The queue entry records the ring index of the first descriptor to release, the index just past the request's last descriptor, and a flag that says whether its descriptors need a release strobe. When the engine reports a new consumed-head position, the tracker walks its own head pointer toward it one ring entry per clock. On each step it counts a removed descriptor. It strobes the index of any descriptor the front request wants released. It reports completion once the head passes that request's end index. Descriptors that lie before a request's first releasable slot, such as header slots, are retired silently.

An abort flush tears the ring down. The flush first retires what the engine has already consumed. It then completes every remaining request with an aborted status, releasing each flagged request's descriptors one per cycle. Finally it zeroes head, tail, generation and the captured head value, and sets the removed count equal to the added count, so the removed count never moves backwards. A request submitted while the engine is not running is queued as an empty aborted request and drained by the same flush. This keeps completion order intact.

Top module: `desc_retire_tracker`

## Requirements
- R1: After reset, sw_head_o, tail_o, gen_o, wb_head_o, removed_o and added_o are 0, rel_o, done_o and progress_o are low, and free_o equals RING_DEPTH-1.
- R2: While run_i is high and the head is not at the captured engine head, the head advances by exactly one entry per cycle, wrapping from RING_DEPTH-1 to 0, and removed_o increments by one per step.
- R3: rel_o is raised with rel_idx_o equal to the current head only when the front request has its release flag set and its release cursor (first index plus descriptors already released) equals the head. The cursor then advances with wrap.
- R4: When the advanced head equals the front request's end index, done_o is raised with done_abort_o = 0 and the request leaves the queue. The next request then becomes the front with its cursor at its own first index.
- R5: Descriptors before the front request's first releasable index, and all descriptors of requests without the release flag, retire with no release strobe.
- R6: progress_o pulses for exactly one cycle after each run of one or more retirement steps ends, and never pulses when no descriptor was retired.
- R7: Outside a flush, the engine head value hw_head_i is captured (shown on wb_head_o) only while run_i is high. A change while run_i is low moves neither the head nor the removed count.
- R8: A request enqueued while running sets its end index to tail_o + enq_ndesc_i modulo RING_DEPTH, moves tail_o there, adds enq_ndesc_i to added_o, and increments gen_o when the addition wraps past the ring end.
- R9: On flush_i the block captures hw_head_i regardless of run_i and retires up to it. It then completes every queued request in order with done_abort_o = 1. Before each flagged request completes, the block strobes that request's remaining indices from its cursor up to, but not including, its end index, one per cycle. flushing_o is high throughout.
- R10: When a flush ends, removed_o equals added_o and sw_head_o, tail_o, gen_o and wb_head_o are 0.
- R11: A request enqueued while run_i is low is stored with first and end index 0, leaves added_o and tail_o unchanged, starts a flush, and completes aborted after all earlier requests, with no release strobe of its own.
- R12: free_o always equals RING_DEPTH-1 minus (added_o - removed_o).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Engine running |
| hw_head_i | input | IDX_W | Ring index the engine has consumed up to |
| flush_i | input | 1 | Start an abort flush |
| enq_i | input | 1 | Submit a request |
| enq_start_i | input | IDX_W | First releasable descriptor index of the request |
| enq_ndesc_i | input | IDX_W | Descriptors the request adds to the ring |
| enq_release_i | input | 1 | Request descriptors need release strobes |
| rel_o | output | 1 | Release strobe |
| rel_idx_o | output | IDX_W | Index being released |
| done_o | output | 1 | Front request completes this cycle |
| done_abort_o | output | 1 | Completion status: 1 aborted, 0 OK |
| progress_o | output | 1 | One-cycle pulse after a retirement run |
| flushing_o | output | 1 | Flush in progress |
| sw_head_o | output | IDX_W | Tracker head pointer |
| tail_o | output | IDX_W | Ring tail (end of last accepted request) |
| gen_o | output | GEN_W | Ring wrap generation |
| wb_head_o | output | IDX_W | Last captured engine head |
| removed_o | output | CNT_W | Descriptors retired |
| added_o | output | CNT_W | Descriptors added |
| free_o | output | CNT_W | Free ring entries |

## Verification
The assertions assume the caller keeps the request queue from overflowing and submits nothing while flushing_o is high. They also assume the engine head never runs past tail_o, so a request's end index is always reached by stepping. The stimulus keeps at most two requests outstanding. It waits for flushing_o to fall and the head to settle before each new scenario. It only moves hw_head_i to indices that the submitted requests already cover, or back to the current head while the engine is stopped.

// File: rtl/desc_ret_pkg.sv
package desc_ret_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FRET   = 2'd1,
        ST_FDRAIN = 2'd2,
        ST_FCLR   = 2'd3
    } trk_state_e;

    // modular add of two ring indices, both below depth
    function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                             int unsigned depth);
        int unsigned s;
        s = a + b;
        return (s >= depth) ? (s - depth) : s;
    endfunction

endpackage

// File: rtl/desc_req_fifo.sv
module desc_req_fifo #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/desc_retire_step.sv
module desc_retire_step
    import desc_ret_pkg::*;
#(
    parameter int unsigned RING_DEPTH = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic [IDX_W-1:0] head,
    input  logic             front_valid,
    input  logic [IDX_W-1:0] f_start,
    input  logic [IDX_W-1:0] f_stop,
    input  logic             f_rel,
    input  logic [IDX_W-1:0] rel_off,
    output logic [IDX_W-1:0] cursor,
    output logic [IDX_W-1:0] head_nxt,
    output logic             rel_hit,
    output logic             end_hit,
    output logic             drain_rel
);
    assign cursor    = IDX_W'(ring_add(32'(f_start), 32'(rel_off), RING_DEPTH));
    assign head_nxt  = IDX_W'(ring_add(32'(head), 32'd1, RING_DEPTH));
    assign rel_hit   = front_valid && f_rel && (cursor == head);
    assign end_hit   = front_valid && (head_nxt == f_stop);
    assign drain_rel = front_valid && f_rel && (cursor != f_stop);
endmodule

// File: rtl/desc_ring_count.sv
module desc_ring_count #(
    parameter int unsigned RING_DEPTH = 16,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned GEN_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [IDX_W-1:0] ndesc,
    input  logic             step,
    input  logic             resync,
    output logic [IDX_W-1:0] tail,
    output logic [GEN_W-1:0] gen,
    output logic [CNT_W-1:0] added,
    output logic [CNT_W-1:0] removed,
    output logic [IDX_W-1:0] new_end,
    output logic [CNT_W-1:0] free
);
    logic [IDX_W:0] sum;
    logic           wrapped;

    assign sum     = {1'b0, tail} + {1'b0, ndesc};
    assign wrapped = (sum >= (IDX_W+1)'(RING_DEPTH));
    assign new_end = wrapped ? IDX_W'(sum - (IDX_W+1)'(RING_DEPTH)) : IDX_W'(sum);
    assign free    = CNT_W'(RING_DEPTH - 1) - (added - removed);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail    <= '0;
            gen     <= '0;
            added   <= '0;
            removed <= '0;
        end else if (resync) begin
            tail    <= '0;
            gen     <= '0;
            removed <= added;
        end else begin
            if (add_en) begin
                tail  <= new_end;
                added <= added + CNT_W'(ndesc);
                if (wrapped) gen <= gen + 1'b1;
            end
            if (step) removed <= removed + 1'b1;
        end
    end
endmodule

// File: rtl/desc_retire_tracker.sv
module desc_retire_tracker
    import desc_ret_pkg::*;
#(
    parameter int unsigned RING_DEPTH  = 16,
    parameter int unsigned QUEUE_DEPTH = 8,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned GEN_W       = 2,
    localparam int unsigned IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [IDX_W-1:0] hw_head_i,
    input  logic             flush_i,
    input  logic             enq_i,
    input  logic [IDX_W-1:0] enq_start_i,
    input  logic [IDX_W-1:0] enq_ndesc_i,
    input  logic             enq_release_i,
    output logic             rel_o,
    output logic [IDX_W-1:0] rel_idx_o,
    output logic             done_o,
    output logic             done_abort_o,
    output logic             progress_o,
    output logic             flushing_o,
    output logic [IDX_W-1:0] sw_head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [GEN_W-1:0] gen_o,
    output logic [IDX_W-1:0] wb_head_o,
    output logic [CNT_W-1:0] removed_o,
    output logic [CNT_W-1:0] added_o,
    output logic [CNT_W-1:0] free_o
);
    typedef struct packed {
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] stop;
        logic             rel;
    } req_t;
    localparam int unsigned ENT_W = $bits(req_t);

    trk_state_e       state;
    logic [IDX_W-1:0] head, tgt, rel_off;
    logic             moved, progress_q;

    req_t             front, push_ent;
    logic             q_empty, q_full, front_valid;
    logic             push, pop, add_en, resync, flush_go, step_w, drain_act;
    logic [IDX_W-1:0] cursor, head_nxt, new_end;
    logic             rel_hit, end_hit, drain_rel;

    assign front_valid = !q_empty;
    assign flush_go    = (state == ST_RUN) && (flush_i || (enq_i && !run_i));
    assign step_w      = (head != tgt) &&
                         (((state == ST_RUN) && run_i) || (state == ST_FRET));
    assign drain_act   = (state == ST_FDRAIN) && front_valid;
    assign pop         = (step_w && end_hit) || (drain_act && !drain_rel);
    assign push        = (state == ST_RUN) && enq_i;
    assign add_en      = push && run_i;
    assign resync      = (state == ST_FCLR);

    always_comb begin
        push_ent.rel = enq_release_i;
        if (run_i) begin
            push_ent.start = enq_start_i;
            push_ent.stop  = new_end;
        end else begin
            push_ent.start = '0;
            push_ent.stop  = '0;
        end
    end

    desc_req_fifo #(.WIDTH(ENT_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (push_ent),
        .pop   (pop),
        .dout  (front),
        .empty (q_empty),
        .full  (q_full)
    );

    desc_retire_step #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_step (
        .head        (head),
        .front_valid (front_valid),
        .f_start     (front.start),
        .f_stop      (front.stop),
        .f_rel       (front.rel),
        .rel_off     (rel_off),
        .cursor      (cursor),
        .head_nxt    (head_nxt),
        .rel_hit     (rel_hit),
        .end_hit     (end_hit),
        .drain_rel   (drain_rel)
    );

    desc_ring_count #(
        .RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .GEN_W(GEN_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .add_en  (add_en),
        .ndesc   (enq_ndesc_i),
        .step    (step_w),
        .resync  (resync),
        .tail    (tail_o),
        .gen     (gen_o),
        .added   (added_o),
        .removed (removed_o),
        .new_end (new_end),
        .free    (free_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            head       <= '0;
            tgt        <= '0;
            rel_off    <= '0;
            moved      <= 1'b0;
            progress_q <= 1'b0;
        end else begin
            moved      <= step_w;
            progress_q <= moved && !step_w;

            case (state)
                ST_RUN:    if (flush_go) state <= ST_FRET;
                ST_FRET:   if (!step_w) state <= ST_FDRAIN;
                ST_FDRAIN: if (!front_valid) state <= ST_FCLR;
                default:   state <= ST_RUN;
            endcase

            if (resync)
                tgt <= '0;
            else if (run_i || (state == ST_FRET) || flush_go)
                tgt <= hw_head_i;

            if (resync)      head <= '0;
            else if (step_w) head <= head_nxt;

            if (resync || pop) rel_off <= '0;
            else if (rel_o)    rel_off <= rel_off + 1'b1;
        end
    end

    assign rel_o        = (step_w && rel_hit) || (drain_act && drain_rel);
    assign rel_idx_o    = cursor;
    assign done_o       = pop;
    assign done_abort_o = (state == ST_FDRAIN);
    assign progress_o   = progress_q;
    assign flushing_o   = (state != ST_RUN);
    assign sw_head_o    = head;
    assign wb_head_o    = tgt;
endmodule

// File: rtl/desc_retire_checker.sv
module desc_retire_checker #(
    parameter int unsigned RING_DEPTH = 16,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned GEN_W      = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             step_w,
    input logic [IDX_W-1:0] sw_head_o,
    input logic [CNT_W-1:0] removed_o,
    input logic [CNT_W-1:0] added_o,
    input logic [IDX_W-1:0] tail_o,
    input logic [GEN_W-1:0] gen_o,
    input logic             rel_o,
    input logic [IDX_W-1:0] rel_idx_o,
    input logic             done_o,
    input logic             done_abort_o,
    input logic             progress_o,
    input logic             flushing_o
);
    p_head_step_r2: assert property (@(posedge clk) disable iff (rst)
        step_w |=> (sw_head_o == (($past(sw_head_o) == IDX_W'(RING_DEPTH - 1)) ?
                                  '0 : IDX_W'($past(sw_head_o) + 1'b1))));

    p_removed_inc_r2: assert property (@(posedge clk) disable iff (rst)
        step_w |=> (removed_o == $past(removed_o) + 1'b1));

    p_rel_at_head_r3: assert property (@(posedge clk) disable iff (rst)
        (rel_o && step_w) |-> (rel_idx_o == sw_head_o));

    p_ok_done_on_step_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !done_abort_o) |-> step_w);

    p_progress_single_r6: assert property (@(posedge clk) disable iff (rst)
        progress_o |=> !progress_o);

    p_progress_after_step_r6: assert property (@(posedge clk) disable iff (rst)
        progress_o |-> $past(step_w, 2));

    p_abort_in_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_abort_o) |-> flushing_o);

    p_resync_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(flushing_o) |-> ((removed_o == added_o) && (sw_head_o == '0) &&
                               (tail_o == '0) && (gen_o == '0)));
endmodule

bind desc_retire_tracker desc_retire_checker #(
    .RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .GEN_W(GEN_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .step_w       (step_w),
    .sw_head_o    (sw_head_o),
    .removed_o    (removed_o),
    .added_o      (added_o),
    .tail_o       (tail_o),
    .gen_o        (gen_o),
    .rel_o        (rel_o),
    .rel_idx_o    (rel_idx_o),
    .done_o       (done_o),
    .done_abort_o (done_abort_o),
    .progress_o   (progress_o),
    .flushing_o   (flushing_o)
);

// File: tb/desc_retire_tracker_test.sv
module desc_retire_tracker_test;
    localparam int CLK_NS = 10;
    localparam int RING   = 16;

    logic        clk, rst, run_i, flush_i, enq_i, enq_release_i;
    logic [3:0]  hw_head_i, enq_start_i, enq_ndesc_i;
    logic        rel_o, done_o, done_abort_o, progress_o, flushing_o;
    logic [3:0]  rel_idx_o, sw_head_o, tail_o, wb_head_o;
    logic [1:0]  gen_o;
    logic [15:0] removed_o, added_o, free_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    int rel_log [256];
    int done_ab [256];
    int rel_n = 0, done_n = 0, prog_n = 0;

    desc_retire_tracker uut (
        .clk(clk), .rst(rst), .run_i(run_i), .hw_head_i(hw_head_i),
        .flush_i(flush_i), .enq_i(enq_i), .enq_start_i(enq_start_i),
        .enq_ndesc_i(enq_ndesc_i), .enq_release_i(enq_release_i),
        .rel_o(rel_o), .rel_idx_o(rel_idx_o), .done_o(done_o),
        .done_abort_o(done_abort_o), .progress_o(progress_o),
        .flushing_o(flushing_o), .sw_head_o(sw_head_o), .tail_o(tail_o),
        .gen_o(gen_o), .wb_head_o(wb_head_o), .removed_o(removed_o),
        .added_o(added_o), .free_o(free_o)
    );

    initial clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (rel_o) begin
                rel_log[rel_n[7:0]] = int'(rel_idx_o);
                rel_n = rel_n + 1;
            end
            if (done_o) begin
                done_ab[done_n[7:0]] = int'(done_abort_o);
                done_n = done_n + 1;
            end
            if (progress_o) prog_n = prog_n + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic free_chk(input string tag);
        chk(tag, int'(free_o), (RING - 1) - (int'(added_o) - int'(removed_o)));
    endtask

    task automatic enq(input int start, input int nd, input bit rel);
        enq_i         = 1'b1;
        enq_start_i   = 4'(start);
        enq_ndesc_i   = 4'(nd);
        enq_release_i = rel;
        @(negedge clk);
        enq_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; run_i = 0; flush_i = 0; enq_i = 0; enq_release_i = 0;
        hw_head_i = 0; enq_start_i = 0; enq_ndesc_i = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 head", int'(sw_head_o), 0);
        chk("R1 tail", int'(tail_o), 0);
        chk("R1 gen", int'(gen_o), 0);
        chk("R1 wb_head", int'(wb_head_o), 0);
        chk("R1 removed", int'(removed_o), 0);
        chk("R1 added", int'(added_o), 0);
        chk("R1 strobes", int'({rel_o, done_o, progress_o}), 0);
        chk("R1 free", int'(free_o), RING - 1);
    endtask

    task automatic t_basic();
        int rb = rel_n, db = done_n, pb = prog_n;
        run_i = 1; hw_head_i = 0;
        @(negedge clk);
        enq(1, 4, 1'b1);   // header at 0, releases 1..3, end 4
        enq(5, 3, 1'b0);   // header at 4, no release, end 7
        chk("R8 tail", int'(tail_o), 7);
        chk("R8 added", int'(added_o), 7);
        chk("R8 gen", int'(gen_o), 0);
        chk("R12 free", int'(free_o), 8);
        hw_head_i = 7;
        settle();
        chk("R2 head", int'(sw_head_o), 7);
        chk("R2 removed", int'(removed_o), 7);
        chk("R5 release count", rel_n - rb, 3);
        for (int i = 0; i < 3; i++)
            chk("R3 release index", rel_log[rb + i], 1 + i);
        chk("R4 done count", done_n - db, 2);
        chk("R4 status ok a", done_ab[db], 0);
        chk("R4 status ok b", done_ab[db + 1], 0);
        chk("R6 progress pulses", prog_n - pb, 1);
        free_chk("R12 free after");
    endtask

    task automatic t_wrap();
        int rb = rel_n, db = done_n;
        enq(8, 12, 1'b1);  // 7+12 wraps to end 3
        chk("R8 wrap end tail", int'(tail_o), 3);
        chk("R8 gen wrap", int'(gen_o), 1);
        hw_head_i = 3;
        settle();
        chk("R2 wrap head", int'(sw_head_o), 3);
        chk("R2 wrap removed", int'(removed_o), 19);
        chk("R3 wrap count", rel_n - rb, 11);
        for (int i = 0; i < 11; i++)
            chk("R3 wrap index", rel_log[rb + i], (8 + i) % RING);
        chk("R4 wrap done", done_n - db, 1);
        chk("R4 wrap status", done_ab[db], 0);
    endtask

    task automatic t_run_low();
        int pb = prog_n;
        run_i = 0;
        @(negedge clk);
        hw_head_i = 9;
        repeat (6) @(negedge clk);
        chk("R7 head held", int'(sw_head_o), 3);
        chk("R7 removed held", int'(removed_o), 19);
        chk("R7 wb_head held", int'(wb_head_o), 3);
        chk("R6 no progress", prog_n - pb, 0);
        hw_head_i = 3;
        @(negedge clk);
        run_i = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_flush();
        int rb, db, pb;
        enq(4, 3, 1'b1);   // header 3, end 6
        enq(7, 4, 1'b1);   // header 6, end 10
        chk("R8 tail two", int'(tail_o), 10);
        rb = rel_n; db = done_n; pb = prog_n;
        run_i = 0; hw_head_i = 5; flush_i = 1;
        @(negedge clk);
        flush_i = 0;
        chk("R9 flushing", int'(flushing_o), 1);
        settle();
        chk("R9 flush done", int'(flushing_o), 0);
        chk("R9 release count", rel_n - rb, 5);
        chk("R9 rel 0", rel_log[rb], 4);
        chk("R9 rel 1", rel_log[rb + 1], 5);
        chk("R9 rel 2", rel_log[rb + 2], 7);
        chk("R9 rel 3", rel_log[rb + 3], 8);
        chk("R9 rel 4", rel_log[rb + 4], 9);
        chk("R9 done count", done_n - db, 2);
        chk("R9 abort a", done_ab[db], 1);
        chk("R9 abort b", done_ab[db + 1], 1);
        chk("R6 flush progress", prog_n - pb, 1);
        chk("R10 removed", int'(removed_o), 26);
        chk("R10 added", int'(added_o), 26);
        chk("R10 head", int'(sw_head_o), 0);
        chk("R10 tail", int'(tail_o), 0);
        chk("R10 gen", int'(gen_o), 0);
        chk("R10 wb_head", int'(wb_head_o), 0);
        free_chk("R12 free flush");
        hw_head_i = 0;
        @(negedge clk);
        run_i = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_idle_submit();
        int rb, db;
        enq(1, 2, 1'b1);   // header 0, end 2
        chk("R8 added idle", int'(added_o), 28);
        rb = rel_n; db = done_n;
        run_i = 0;
        @(negedge clk);
        enq(9, 5, 1'b1);   // not running: queued as empty aborted
        settle();
        chk("R11 release count", rel_n - rb, 1);
        chk("R11 release idx", rel_log[rb], 1);
        chk("R11 done count", done_n - db, 2);
        chk("R11 abort a", done_ab[db], 1);
        chk("R11 abort b", done_ab[db + 1], 1);
        chk("R11 added unchanged", int'(added_o), 28);
        chk("R11 removed", int'(removed_o), 28);
        chk("R11 tail", int'(tail_o), 0);
        free_chk("R12 free end");
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_run_low();
        t_flush();
        t_idle_submit();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule